// File: doc/BRIEF.md
# Counter Array Compare/Capture Channel

One channel of a programmable counter array. It watches a free-running counter shared by all channels and owns a compare/capture register whose width matches the counter, plus a 7-bit mode register. The mode register selects one job for the channel. It can latch the counter when an external pin rises, falls or changes in either direction. It can signal when the counter reaches the stored value, either as a plain timer event or by inverting an output pin. It can generate pulse-width modulation from the low half of the counter. On a channel built with watchdog capability, it can request a system reset on a match.

The channel reports a one-cycle event strobe on every capture and on every timer match. It also drives an output pin and a reset-request strobe. Register writes arrive as separate byte strobes for the low half, the high half and the mode register. The surrounding array does the bus decoding and gathers interrupts from all channels.

Top module: `pca_ch`

## Requirements
- R1: After reset, `cap_o`, `mode_o`, `pin_o`, `event_o` and `rst_req_o` are all zero.
- R2: The mode bits are, from bit 6 down to bit 0: compare enable, capture-rise, capture-fall, match, toggle, PWM, interrupt enable. All zeros, and every combination not named in R3 to R11, does nothing: no event, no capture, and `pin_o` is held.
- R3: Capture mode is match, toggle and PWM all 0 with at least one capture bit set. With only capture-rise set, a rising pin edge loads `cnt_i` into `cap_o` and pulses `event_o`. This happens at the third clock edge after the pin level is first sampled (two synchronizer flops, then one edge stage).
- R4: With only capture-fall set, a falling pin edge captures and pulses `event_o`. A rising edge does nothing.
- R5: With both capture bits set, every pin edge captures and pulses `event_o`.
- R6: Mode 7'b100100x is the software timer. `event_o` pulses once, one cycle after the clock edge at which `cnt_i` changes to a value equal to `cap_o`.
- R7: A match is evaluated only when `cnt_i` differs from its value at the previous edge. A counter that stops on the compare value does not produce another event.
- R8: Mode 7'b100110x is high-speed output. On each match, `pin_o` inverts at the same edge that raises `event_o`.
- R9: Mode 7'b1000010 is PWM. At each edge, `pin_o` becomes 1 if the low byte of `cnt_i` is at or above the low byte of `cap_o`, and 0 otherwise. No events are raised.
- R10: In PWM mode, when the counter's low byte goes from 8'hFF to 8'h00, the high byte of `cap_o` is copied into its low byte.
- R11: On a watchdog-capable channel with `wdt_en_i` high, a match in any mode with compare enable and match set, PWM clear and both capture bits clear pulses `rst_req_o` for one cycle. With `wdt_en_i` low, `rst_req_o` stays low.
- R12: A write to the low byte clears mode bit 6. A write to the high byte sets it. Register writes take priority over capture and PWM reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cnt_i | input | 16 | Shared counter value |
| pin_i | input | 1 | External capture pin, asynchronous |
| wdt_en_i | input | 1 | Watchdog reset enable |
| mode_we_i | input | 1 | Write mode register from `wdata_i[6:0]` |
| cap_lo_we_i | input | 1 | Write low byte of compare/capture register |
| cap_hi_we_i | input | 1 | Write high byte of compare/capture register |
| wdata_i | input | 8 | Write data |
| cap_o | output | 16 | Compare/capture register |
| mode_o | output | 7 | Mode register |
| pin_o | output | 1 | Toggle / PWM output pin |
| event_o | output | 1 | One-cycle capture or match strobe |
| rst_req_o | output | 1 | One-cycle watchdog reset request |

## Verification
Each capture selection sees the same rise-then-fall pin pulse, so the event counts (1 from a single-edge mode, 2 from both edges) and the captured values show which edge triggered. The timer pattern sweeps the counter through the compare value and then parks it exactly on that value, which separates a change-qualified match from a level match. A full 256-step sweep under PWM counts the high cycles against the threshold. A later sweep across a low-byte wrap shows the reload. An invalid all-ones mode is driven with pin edges and a counter crossing the compare value, and must produce no effect.

// File: rtl/pca_ch_pkg.sv
package pca_ch_pkg;
  localparam int MODE_W = 7;

  typedef struct packed {
    logic ecom;
    logic capp;
    logic capn;
    logic mat;
    logic tog;
    logic pwm;
    logic eccf;
  } mode_t;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_CAPTURE,
    OP_SWTMR,
    OP_HSO,
    OP_PWM
  } op_e;
endpackage

// File: rtl/pca_edge_sync.sv
module pca_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], pin_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/pca_mode_dec.sv
module pca_mode_dec
  import pca_ch_pkg::*;
#(
  parameter bit WDT_CAPABLE = 1'b1
) (
  input  mode_t mode_i,
  input  logic  wdt_en_i,
  output op_e   op_o,
  output logic  wdt_arm_o
);
  logic caps;
  logic cmp_match;

  assign caps      = mode_i.capp | mode_i.capn;
  assign cmp_match = mode_i.ecom & mode_i.mat & ~mode_i.pwm & ~caps;

  always_comb begin
    op_o = OP_IDLE;
    if (!mode_i.mat && !mode_i.tog && !mode_i.pwm && caps)
      op_o = OP_CAPTURE;
    else if (cmp_match)
      op_o = mode_i.tog ? OP_HSO : OP_SWTMR;
    else if (mode_i.ecom && mode_i.pwm && !mode_i.mat && !mode_i.tog &&
             !mode_i.eccf && !caps)
      op_o = OP_PWM;
  end

  generate
    if (WDT_CAPABLE) begin : g_wdt
      assign wdt_arm_o = wdt_en_i & cmp_match;
    end else begin : g_no_wdt
      logic unused_wdt;
      assign unused_wdt = wdt_en_i;
      assign wdt_arm_o  = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/pca_match.sv
module pca_match #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic             match_o,
  output logic             lo_wrap_o
);
  localparam int HALF_W = CNT_W / 2;

  logic [CNT_W-1:0] cnt_q;
  logic             cnt_chg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_i;
  end

  // only a moving counter may match
  assign cnt_chg   = cnt_i != cnt_q;
  assign match_o   = cnt_chg && (cnt_i == cmp_i);
  assign lo_wrap_o = (cnt_q[HALF_W-1:0] == {HALF_W{1'b1}}) &&
                     (cnt_i[HALF_W-1:0] == '0);
endmodule

// File: rtl/pca_ch.sv
module pca_ch
  import pca_ch_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter bit WDT_CAPABLE = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [CNT_W-1:0]    cnt_i,
  input  logic                pin_i,
  input  logic                wdt_en_i,
  input  logic                mode_we_i,
  input  logic                cap_lo_we_i,
  input  logic                cap_hi_we_i,
  input  logic [CNT_W/2-1:0]  wdata_i,
  output logic [CNT_W-1:0]    cap_o,
  output logic [MODE_W-1:0]   mode_o,
  output logic                pin_o,
  output logic                event_o,
  output logic                rst_req_o
);
  localparam int HALF_W = CNT_W / 2;

  mode_t            mode_q;
  logic [CNT_W-1:0] cap_q;
  logic             pin_q, evt_q, rst_q;
  logic             rise, fall, match, lo_wrap, wdt_arm;
  logic             cap_fire, tmr_fire, pwm_lvl;
  op_e              op;

  pca_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  pca_mode_dec #(.WDT_CAPABLE(WDT_CAPABLE)) u_dec (
    .mode_i    (mode_q),
    .wdt_en_i  (wdt_en_i),
    .op_o      (op),
    .wdt_arm_o (wdt_arm)
  );

  pca_match #(.CNT_W(CNT_W)) u_match (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cnt_i     (cnt_i),
    .cmp_i     (cap_q),
    .match_o   (match),
    .lo_wrap_o (lo_wrap)
  );

  assign cap_fire = (op == OP_CAPTURE) &&
                    ((mode_q.capp && rise) || (mode_q.capn && fall));
  assign tmr_fire = match && (op == OP_SWTMR || op == OP_HSO);
  assign pwm_lvl  = cnt_i[HALF_W-1:0] >= cap_q[HALF_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q <= 1'b0;
      rst_q <= 1'b0;
      pin_q <= 1'b0;
    end else begin
      evt_q <= cap_fire | tmr_fire;
      rst_q <= match & wdt_arm;
      if (op == OP_HSO && match) pin_q <= ~pin_q;
      else if (op == OP_PWM)     pin_q <= pwm_lvl;
    end
  end

  // software writes win over hardware updates
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q <= '0;
    end else begin
      if (cap_lo_we_i)                 cap_q[HALF_W-1:0] <= wdata_i;
      else if (cap_fire)               cap_q[HALF_W-1:0] <= cnt_i[HALF_W-1:0];
      else if (op == OP_PWM && lo_wrap) cap_q[HALF_W-1:0] <= cap_q[CNT_W-1:HALF_W];

      if (cap_hi_we_i)   cap_q[CNT_W-1:HALF_W] <= wdata_i;
      else if (cap_fire) cap_q[CNT_W-1:HALF_W] <= cnt_i[CNT_W-1:HALF_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
    end else begin
      if (mode_we_i) mode_q <= mode_t'(wdata_i[MODE_W-1:0]);
      if (cap_lo_we_i) mode_q.ecom <= 1'b0;
      if (cap_hi_we_i) mode_q.ecom <= 1'b1;
    end
  end

  assign cap_o     = cap_q;
  assign mode_o    = mode_q;
  assign pin_o     = pin_q;
  assign event_o   = evt_q;
  assign rst_req_o = rst_q;
endmodule

// File: rtl/pca_ch_chk.sv
module pca_ch_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] cnt_i,
  input logic        wdt_en_i,
  input logic        mode_we_i,
  input logic        cap_lo_we_i,
  input logic        cap_hi_we_i,
  input logic [15:0] cap_o,
  input logic [6:0]  mode_o,
  input logic        pin_o,
  input logic        event_o,
  input logic        rst_req_o
);
  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |-> $past(mode_o) != 7'h00);

  assert_capture_value_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_o && $past(mode_o[3:1]) == 3'b000 && $past(mode_o[5:4]) != 2'b00 &&
     !$past(cap_lo_we_i) && !$past(cap_hi_we_i)) |-> cap_o == $past(cnt_i));

  assert_no_retrigger_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_o && $past(mode_o[6:1]) == 6'b100100) |-> $past(cnt_i) != $past(cnt_i, 2));

  assert_hso_toggle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_o[6:1]) == 6'b100110) |-> ((pin_o != $past(pin_o)) == event_o));

  assert_pwm_level_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_o) == 7'b1000010) |-> pin_o == ($past(cnt_i[7:0]) >= $past(cap_o[7:0])));

  assert_wdt_gate_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> ($past(wdt_en_i) && $past(mode_o[6]) && $past(mode_o[3])));

  assert_lo_clears_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_lo_we_i && !cap_hi_we_i) |=> !mode_o[6]);

  assert_hi_sets_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_hi_we_i && !mode_we_i) |=> mode_o[6]);
endmodule

bind pca_ch pca_ch_chk chk_i (.*);

// File: tb/pca_ch_tb_top.sv
`timescale 1ns/1ps
module pca_ch_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cnt = '0;
  logic        pin = 1'b0, wdt_en = 1'b0;
  logic        mode_we = 1'b0, lo_we = 1'b0, hi_we = 1'b0;
  logic [7:0]  wdata = '0;
  logic [15:0] cap_o;
  logic [6:0]  mode_o;
  logic        pin_o, event_o, rst_req_o;

  int n_chk = 0, n_fail = 0;
  int n_evt = 0, n_rst = 0, n_tog = 0;
  bit pin_last = 1'b0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  pca_ch dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cnt_i(cnt), .pin_i(pin), .wdt_en_i(wdt_en),
    .mode_we_i(mode_we), .cap_lo_we_i(lo_we), .cap_hi_we_i(hi_we), .wdata_i(wdata),
    .cap_o(cap_o), .mode_o(mode_o), .pin_o(pin_o), .event_o(event_o),
    .rst_req_o(rst_req_o)
  );

  // reference model
  logic [15:0] m_cap, m_prev;
  logic [6:0]  m_mode;
  bit          m_pin, m_evt, m_rst;
  bit          hist[$];

  function automatic int kind_of(input logic [6:0] m);
    if (m == 7'h00) return 0;
    casez (m)
      7'b?10000?, 7'b?01000?, 7'b?11000?: return 1;
      7'b100100?: return 2;
      7'b100110?: return 3;
      7'b1000010: return 4;
      default:    return 5;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cap = '0; m_prev = '0; m_mode = '0;
      m_pin = 0; m_evt = 0; m_rst = 0;
      hist = '{0, 0, 0};
    end else begin
      automatic int          k    = kind_of(m_mode);
      automatic bit          rise = hist[1] && !hist[2];
      automatic bit          fall = !hist[1] && hist[2];
      automatic bit          hit  = (cnt != m_prev) && (cnt == m_cap);
      automatic bit          capt = (k == 1) && ((m_mode[5] && rise) || (m_mode[4] && fall));
      automatic logic [15:0] n_cap = m_cap;
      automatic logic [6:0]  n_mode = m_mode;
      m_evt = capt || ((k == 2 || k == 3) && hit);
      m_rst = (k == 2 || k == 3) && hit && wdt_en;
      if (k == 3 && hit) m_pin = !m_pin;
      else if (k == 4) m_pin = cnt[7:0] >= m_cap[7:0];
      if (capt) n_cap = cnt;
      if (k == 4 && m_prev[7:0] == 8'hFF && cnt[7:0] == 8'h00) n_cap[7:0] = m_cap[15:8];
      if (lo_we) n_cap[7:0] = wdata;
      if (hi_we) n_cap[15:8] = wdata;
      if (mode_we) n_mode = wdata[6:0];
      if (lo_we) n_mode[6] = 1'b0;
      if (hi_we) n_mode[6] = 1'b1;
      m_cap = n_cap; m_mode = n_mode; m_prev = cnt;
      hist.push_front(pin);
      void'(hist.pop_back());
    end
  end

  // per-cycle comparison and event tallies
  always @(negedge clk) begin
    if (rst_n) begin
      n_chk++;
      if (cap_o !== m_cap || mode_o !== m_mode || pin_o !== m_pin ||
          event_o !== m_evt || rst_req_o !== m_rst) begin
        n_fail++;
        $display("FAIL %s model: cap %h/%h mode %h/%h pin %b/%b evt %b/%b rst %b/%b",
                 cur_req, cap_o, m_cap, mode_o, m_mode, pin_o, m_pin,
                 event_o, m_evt, rst_req_o, m_rst);
      end
      if (event_o) n_evt++;
      if (rst_req_o) n_rst++;
      if (pin_o != pin_last) n_tog++;
      pin_last = pin_o;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic run(input int n);
    repeat (n) begin @(negedge clk); cnt = cnt + 16'd1; end
    cyc(3);
  endtask

  task automatic wr(input int sel, input logic [7:0] d);
    @(negedge clk);
    wdata = d;
    mode_we = (sel == 0); lo_we = (sel == 1); hi_we = (sel == 2);
    @(negedge clk);
    mode_we = 0; lo_we = 0; hi_we = 0;
    #1;
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    int e0, t0, r0, hi_cnt;
    bit p0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    cyc(2);
    // R1
    check("R1", "cap", cap_o, 0); check("R1", "mode", mode_o, 0);
    check("R1", "outs", {pin_o, event_o, rst_req_o}, 0);

    // R3 rising only
    cur_req = "R3"; cnt = 16'h1234; wr(0, 8'h20);
    e0 = n_evt; pin = 1; cyc(6); pin = 0; cyc(6);
    check("R3", "events", n_evt - e0, 1); check("R3", "cap", cap_o, 16'h1234);

    // R4 falling only
    cur_req = "R4"; cnt = 16'hBEEF; wr(0, 8'h10);
    e0 = n_evt; pin = 1; cyc(6); cnt = 16'h4321; pin = 0; cyc(6);
    check("R4", "events", n_evt - e0, 1); check("R4", "cap", cap_o, 16'h4321);

    // R5 both edges
    cur_req = "R5"; cnt = 16'h0A0A; wr(0, 8'h30);
    e0 = n_evt; pin = 1; cyc(6); cnt = 16'h0B0B; pin = 0; cyc(6);
    check("R5", "events", n_evt - e0, 2); check("R5", "cap", cap_o, 16'h0B0B);

    // R12 write side effects on compare enable
    cur_req = "R12"; wr(0, 8'h48);
    wr(1, 8'h05); check("R12", "mode after lo write", mode_o, 7'h08);
    wr(2, 8'h01); check("R12", "mode after hi write", mode_o, 7'h48);

    // R6 software timer
    cur_req = "R6"; cnt = 16'h0100; cyc(2);
    e0 = n_evt; run(10);
    check("R6", "events", n_evt - e0, 1); check("R6", "cap", cap_o, 16'h0105);

    // R7 stopped counter on compare value
    cur_req = "R7"; cnt = 16'h0104; cyc(2);
    e0 = n_evt; run(1); cyc(10);
    check("R7", "events", n_evt - e0, 1);

    // R8 high-speed output
    cur_req = "R8"; wr(0, 8'h4C); cnt = 16'h0100; cyc(2);
    e0 = n_evt; t0 = n_tog; p0 = pin_o; run(10);
    check("R8", "toggles", n_tog - t0, 1); check("R8", "pin", pin_o, !p0);
    check("R8", "events", n_evt - e0, 1);

    // R11 watchdog
    cur_req = "R11"; wr(0, 8'h48); wdt_en = 1; cnt = 16'h0100; cyc(2);
    r0 = n_rst; run(10);
    check("R11", "rst pulses enabled", n_rst - r0, 1);
    wdt_en = 0; cnt = 16'h0100; cyc(2);
    r0 = n_rst; run(10);
    check("R11", "rst pulses disabled", n_rst - r0, 0);

    // R2 invalid and idle modes
    cur_req = "R2"; wr(0, 8'h7F); cnt = 16'h0100; cyc(2);
    e0 = n_evt; t0 = n_tog; pin = 1; cyc(6); pin = 0; run(10);
    check("R2", "events invalid", n_evt - e0, 0); check("R2", "cap", cap_o, 16'h0105);
    check("R2", "toggles invalid", n_tog - t0, 0);
    wr(0, 8'h00); cnt = 16'h0100; cyc(2);
    e0 = n_evt; pin = 1; cyc(6); pin = 0; run(10);
    check("R2", "events idle", n_evt - e0, 0); check("R2", "cap idle", cap_o, 16'h0105);

    // R9 PWM duty over one low-byte sweep
    cur_req = "R9"; wr(1, 8'h40); wr(2, 8'h40); wr(0, 8'h42);
    cnt = 16'h0000; cyc(3);
    hi_cnt = 0; e0 = n_evt;
    repeat (256) begin @(negedge clk); if (pin_o) hi_cnt++; cnt = cnt + 16'd1; end
    cyc(3);
    check("R9", "high cycles", hi_cnt, 192); check("R9", "events", n_evt - e0, 0);

    // R10 reload on low-byte wrap
    cur_req = "R10"; wr(2, 8'h80);
    check("R10", "cap before wrap", cap_o, 16'h8040);
    cnt = 16'h01F0; cyc(2); run(20);
    check("R10", "cap after wrap", cap_o, 16'h8080);

    cyc(4);
    finish_up();
  end
endmodule